// File: doc/BRIEF.md
# Parallel NOR Flash Command Decoder

This block models the device side of a 16-bit parallel NOR flash that follows the classic unlock-key command protocol. A host issues word writes and word reads on a simple synchronous bus. The block decodes the multi-write key sequences that select its operating modes: returning to array reads, reading the identification codes, answering the common flash interface query table, programming a word, erasing one sector or the whole array, and a bypass mode that shortens repeated programming.

Programming can only clear bits: the stored word becomes the old word ANDed with the new data. Program and erase are embedded operations. They keep the block busy for a fixed number of clock cycles set by a parameter. While busy, every read returns a status word instead of array data, and every write is ignored. The storage is a small array split into equal sectors, and the geometry reported through the query table is derived from the sector parameters.

Top module: `nor_cmd_flash`

## Requirements
- R1: After the key writes (0xAA at word address 0x555, then 0x55 at 0x2AA), writing 0x90 at 0x555 enters identification mode. In that mode word address 0 reads 0x00BF and word address 1 reads 0x236D. Any other address reads 0x0000.
- R2: When the block is idle, a write whose low byte is 0xF0, at any address and outside a program data phase, returns it to array-read mode. This applies from identification mode, from query mode and from a partial key sequence.
- R3: Program is the two key writes, 0xA0 at 0x555, then one data write at the target address. The stored word becomes old AND data: programming 0x0055 and then 0x00A5 into an erased word reads 0x0005.
- R4: Sector erase is the two key writes, 0x80 at 0x555, the two key writes again, then 0x30 at any address inside the target sector. Afterwards every word of that sector reads 0xFFFF and the other sectors keep their contents.
- R5: Chip erase uses the same sequence but ends with 0x10 at 0x555. Afterwards every word reads 0xFFFF.
- R6: The busy output stays high for exactly BUSY_CYCLES cycles after the write that starts an operation. A read issued while busy returns the status word: high byte 0x00, bit 7 = 0 for an erase or the inverse of data bit 7 for a program, and bit 6 starting at 0 and inverting on each successive status read of the same operation. Bits 5 to 0 read 0.
- R7: Once busy falls, repeated reads of the same word return the same array value.
- R8: The key writes followed by 0x20 at 0x555 enter bypass mode. In bypass mode, 0xA0 at any address followed by a data write programs that word, and the block returns to bypass mode afterwards. A write of 0x00 leaves bypass mode, after which a bare 0xA0 plus data write changes nothing.
- R9: Only address bits 10 to 0 take part in command decoding, so key and command writes at 0x5555 and 0x2AAA act like writes at 0x555 and 0x2AA.
- R10: A write of 0x98 at word address 0x55 in array-read mode enters query mode. It then reads 0x0051, 0x0052 and 0x0059 at 0x10, 0x11 and 0x12, and 0x0001 (one erase region) at 0x2C. It reads the sector count minus one as low byte at 0x2D and high byte at 0x2E, and the sector size in bytes divided by 256 as low byte at 0x2F and high byte at 0x30.
- R11: A write that does not match the next expected step of a key or erase sequence abandons the sequence. The block returns to array-read mode and starts no operation.
- R12: Writes issued while busy are ignored, including 0xF0, and do not advance any sequence.
- R13: After reset the block is idle in array-read mode, the read data output is 0x0000, and every word of the array reads 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | Word address for reads and writes |
| wdata | input | 16 | Write data; commands use the low byte |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe; result appears on rd_data the next cycle |
| rd_data | output | 16 | Registered read result, held between reads |
| busy | output | 1 | High while a program or erase is in progress |

## Verification
A wrong sequence state stays hidden until the next read. The next read then returns identification or query values where array data was expected, or the reverse. A write lost in a key sequence shows up as an array word that kept its old value, with busy never rising. A wrong busy count or a stuck toggle bit shows within the BUSY_CYCLES window, either on the busy pin or on bit 6 of two back-to-back status reads. An array update that is not AND-only, or an erase that clears the wrong range, only appears when the affected words are read back, so the checks read words inside and outside each erased sector.

// File: rtl/nor_flash_pkg.sv
package nor_flash_pkg;

  typedef enum logic [3:0] {
    ST_ARRAY,
    ST_KEY1,
    ST_KEY2,
    ST_PGM_DATA,
    ST_ERS_KEY0,
    ST_ERS_KEY1,
    ST_ERS_PICK,
    ST_IDENT,
    ST_QUERY,
    ST_BYPASS,
    ST_BYP_DATA,
    ST_BUSY
  } seq_state_t;

  typedef enum logic [1:0] {
    OP_IDLE,
    OP_PROGRAM,
    OP_SECT_ERASE,
    OP_CHIP_ERASE
  } op_kind_t;

  localparam int CMD_ADDR_BITS = 11;

  localparam logic [CMD_ADDR_BITS-1:0] KEY_ADDR_A = 11'h555;
  localparam logic [CMD_ADDR_BITS-1:0] KEY_ADDR_B = 11'h2AA;
  localparam logic [CMD_ADDR_BITS-1:0] QUERY_ADDR = 11'h055;

  localparam logic [7:0] C_KEY_A       = 8'hAA;
  localparam logic [7:0] C_KEY_B       = 8'h55;
  localparam logic [7:0] C_IDENT       = 8'h90;
  localparam logic [7:0] C_QUERY       = 8'h98;
  localparam logic [7:0] C_PROGRAM     = 8'hA0;
  localparam logic [7:0] C_ERASE_SETUP = 8'h80;
  localparam logic [7:0] C_SECTOR      = 8'h30;
  localparam logic [7:0] C_CHIP        = 8'h10;
  localparam logic [7:0] C_BYPASS      = 8'h20;
  localparam logic [7:0] C_BYP_EXIT    = 8'h00;
  localparam logic [7:0] C_RESET       = 8'hF0;

  // Programming can only pull bits low.
  function automatic logic [15:0] and_program(input logic [15:0] old_w,
                                              input logic [15:0] new_w);
    return old_w & new_w;
  endfunction

  function automatic logic [15:0] ident_word(input logic [7:0] off);
    case (off)
      8'h00:   return 16'h00BF;
      8'h01:   return 16'h236D;
      default: return 16'h0000;
    endcase
  endfunction

  // Query table; geometry fields derive from the array parameters.
  function automatic logic [15:0] query_word(input logic [7:0] off,
                                             input int unsigned sectors,
                                             input int unsigned sector_words);
    int unsigned cnt_m1;
    int unsigned units;
    cnt_m1 = sectors - 1;
    units  = (sector_words * 2) / 256;
    case (off)
      8'h10:   return 16'h0051;
      8'h11:   return 16'h0052;
      8'h12:   return 16'h0059;
      8'h2C:   return 16'h0001;
      8'h2D:   return {8'h00, 8'(cnt_m1)};
      8'h2E:   return {8'h00, 8'(cnt_m1 >> 8)};
      8'h2F:   return {8'h00, 8'(units)};
      8'h30:   return {8'h00, 8'(units >> 8)};
      default: return 16'h0000;
    endcase
  endfunction

  function automatic logic [15:0] status_word(input logic is_erase,
                                              input logic data7,
                                              input logic toggle);
    return {8'h00, (is_erase ? 1'b0 : ~data7), toggle, 6'b000000};
  endfunction

endpackage

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
  parameter int unsigned BUSY_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int unsigned CW = $clog2(BUSY_CYCLES + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= CW'(BUSY_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign busy = (cnt_q != '0);
  assign done = (cnt_q == CW'(1));

  // R6
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));

endmodule

// File: rtl/nor_word_array.sv
module nor_word_array
  import nor_flash_pkg::*;
#(
  parameter int unsigned SECTORS      = 4,
  parameter int unsigned SECTOR_WORDS = 256
) (
  input  logic                                           clk,
  input  logic                                           rst_n,
  input  logic [$clog2(SECTORS*SECTOR_WORDS)-1:0]        rd_idx,
  output logic [15:0]                                    rd_word,
  input  logic                                           prog_en,
  input  logic [$clog2(SECTORS*SECTOR_WORDS)-1:0]        prog_idx,
  input  logic [15:0]                                    prog_data,
  input  logic                                           erase_en,
  input  logic                                           erase_all,
  input  logic [$clog2(SECTORS)-1:0]                     erase_sec
);
  localparam int unsigned DEPTH  = SECTORS * SECTOR_WORDS;
  localparam int unsigned IDX_W  = $clog2(DEPTH);
  localparam int unsigned WORD_W = $clog2(SECTOR_WORDS);
  localparam int unsigned SEC_W  = $clog2(SECTORS);

  logic [15:0]             mem     [DEPTH];
  logic [SECTOR_WORDS-1:0] written [SECTORS];
  logic [SECTORS-1:0]      wipe;
  logic [15:0]             old_word;

  // One wipe strobe per sector.
  for (genvar g = 0; g < SECTORS; g++) begin : g_wipe
    assign wipe[g] = erase_en && (erase_all || erase_sec == SEC_W'(g));
  end

  // A word never written since its last erase reads as all ones.
  assign rd_word = written[rd_idx[IDX_W-1:WORD_W]][rd_idx[WORD_W-1:0]]
                   ? mem[rd_idx] : 16'hFFFF;

  assign old_word = written[prog_idx[IDX_W-1:WORD_W]][prog_idx[WORD_W-1:0]]
                    ? mem[prog_idx] : 16'hFFFF;

  always_ff @(posedge clk) begin
    if (prog_en) begin
      mem[prog_idx] <= and_program(old_word, prog_data);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < SECTORS; s++) begin
        written[s] <= '0;
      end
    end else begin
      for (int s = 0; s < SECTORS; s++) begin
        if (wipe[s]) begin
          written[s] <= '0;
        end
      end
      if (prog_en) begin
        written[prog_idx[IDX_W-1:WORD_W]][prog_idx[WORD_W-1:0]] <= 1'b1;
      end
    end
  end

  // R3
  prog_and_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prog_en |=> ((mem[$past(prog_idx)] & ~$past(old_word)) == 16'h0000));

endmodule

// File: rtl/nor_seq_decoder.sv
module nor_seq_decoder
  import nor_flash_pkg::*;
#(
  parameter int unsigned IDX_W = 10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [CMD_ADDR_BITS-1:0] cmd_addr,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [15:0]              wdata,
  input  logic                     op_done,
  output seq_state_t               state,
  output logic                     op_start,
  output op_kind_t                 op_kind,
  output logic [IDX_W-1:0]         op_idx,
  output logic [15:0]              op_data
);
  seq_state_t       st_q, st_d;
  op_kind_t         kind_q, kind_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [15:0]      data_q, data_d;
  logic             byp_q, byp_d;
  logic             start;

  logic [7:0] cmd;
  logic       at_a;
  logic       key_a;
  logic       key_b;

  assign cmd   = wdata[7:0];
  assign at_a  = (cmd_addr == KEY_ADDR_A);
  assign key_a = at_a && (cmd == C_KEY_A);
  assign key_b = (cmd_addr == KEY_ADDR_B) && (cmd == C_KEY_B);

  always_comb begin
    st_d   = st_q;
    kind_d = kind_q;
    idx_d  = idx_q;
    data_d = data_q;
    byp_d  = byp_q;
    start  = 1'b0;
    if (st_q == ST_BUSY) begin
      if (op_done) st_d = byp_q ? ST_BYPASS : ST_ARRAY;
    end else if (wr_en) begin
      if (st_q == ST_PGM_DATA || st_q == ST_BYP_DATA) begin
        start  = 1'b1;
        kind_d = OP_PROGRAM;
        idx_d  = wr_idx;
        data_d = wdata;
        byp_d  = (st_q == ST_BYP_DATA);
        st_d   = ST_BUSY;
      end else if (cmd == C_RESET) begin
        st_d = ST_ARRAY;
      end else begin
        case (st_q)
          ST_ARRAY: begin
            if (key_a) st_d = ST_KEY1;
            else if (cmd == C_QUERY && cmd_addr == QUERY_ADDR) st_d = ST_QUERY;
          end
          ST_KEY1: st_d = key_b ? ST_KEY2 : ST_ARRAY;
          ST_KEY2: begin
            st_d = ST_ARRAY;
            if (at_a) begin
              case (cmd)
                C_IDENT:       st_d = ST_IDENT;
                C_PROGRAM:     st_d = ST_PGM_DATA;
                C_ERASE_SETUP: st_d = ST_ERS_KEY0;
                C_BYPASS:      st_d = ST_BYPASS;
                default:       st_d = ST_ARRAY;
              endcase
            end
          end
          ST_ERS_KEY0: st_d = key_a ? ST_ERS_KEY1 : ST_ARRAY;
          ST_ERS_KEY1: st_d = key_b ? ST_ERS_PICK : ST_ARRAY;
          ST_ERS_PICK: begin
            st_d = ST_ARRAY;
            if (cmd == C_SECTOR) begin
              start  = 1'b1;
              kind_d = OP_SECT_ERASE;
              idx_d  = wr_idx;
              byp_d  = 1'b0;
              st_d   = ST_BUSY;
            end else if (cmd == C_CHIP && at_a) begin
              start  = 1'b1;
              kind_d = OP_CHIP_ERASE;
              byp_d  = 1'b0;
              st_d   = ST_BUSY;
            end
          end
          ST_BYPASS: begin
            if (cmd == C_BYP_EXIT) st_d = ST_ARRAY;
            else if (cmd == C_PROGRAM) st_d = ST_BYP_DATA;
          end
          default: st_d = st_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= ST_ARRAY;
      kind_q <= OP_IDLE;
      idx_q  <= '0;
      data_q <= '0;
      byp_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      kind_q <= kind_d;
      idx_q  <= idx_d;
      data_q <= data_d;
      byp_q  <= byp_d;
    end
  end

  assign state    = st_q;
  assign op_start = start;
  assign op_kind  = kind_q;
  assign op_idx   = idx_q;
  assign op_data  = data_q;

  // R11
  key_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_KEY1 && wr_en && cmd_addr != KEY_ADDR_B) |=> (st_q == ST_ARRAY));

endmodule

// File: rtl/nor_cmd_flash.sv
module nor_cmd_flash
  import nor_flash_pkg::*;
#(
  parameter int unsigned ADDR_W       = 16,
  parameter int unsigned SECTORS      = 4,
  parameter int unsigned SECTOR_WORDS = 256,
  parameter int unsigned BUSY_CYCLES  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [15:0]       rd_data,
  output logic              busy
);
  localparam int unsigned DEPTH  = SECTORS * SECTOR_WORDS;
  localparam int unsigned IDX_W  = $clog2(DEPTH);
  localparam int unsigned WORD_W = $clog2(SECTOR_WORDS);

  seq_state_t       state;
  logic             op_start;
  op_kind_t         op_kind;
  logic [IDX_W-1:0] op_idx;
  logic [15:0]      op_data;
  logic             op_done;
  logic             busy_w;
  logic [15:0]      arr_word;
  logic [15:0]      rd_mux;
  logic [15:0]      rd_q;
  logic             tog_q;
  logic             is_erase;
  logic             unused_addr_hi;

  assign unused_addr_hi = ^addr[ADDR_W-1:CMD_ADDR_BITS];
  assign is_erase = (op_kind == OP_SECT_ERASE) || (op_kind == OP_CHIP_ERASE);

  nor_seq_decoder #(.IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .cmd_addr (addr[CMD_ADDR_BITS-1:0]),
    .wr_idx   (addr[IDX_W-1:0]),
    .wdata    (wdata),
    .op_done  (op_done),
    .state    (state),
    .op_start (op_start),
    .op_kind  (op_kind),
    .op_idx   (op_idx),
    .op_data  (op_data)
  );

  nor_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk   (clk),
    .rst_n (rst_n),
    .start (op_start),
    .busy  (busy_w),
    .done  (op_done)
  );

  nor_word_array #(.SECTORS(SECTORS), .SECTOR_WORDS(SECTOR_WORDS)) u_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (addr[IDX_W-1:0]),
    .rd_word   (arr_word),
    .prog_en   (op_done && op_kind == OP_PROGRAM),
    .prog_idx  (op_idx),
    .prog_data (op_data),
    .erase_en  (op_done && is_erase),
    .erase_all (op_kind == OP_CHIP_ERASE),
    .erase_sec (op_idx[IDX_W-1:WORD_W])
  );

  always_comb begin
    if (busy_w) begin
      rd_mux = status_word(is_erase, op_data[7], tog_q);
    end else begin
      case (state)
        ST_IDENT: rd_mux = ident_word(addr[7:0]);
        ST_QUERY: rd_mux = query_word(addr[7:0], SECTORS, SECTOR_WORDS);
        default:  rd_mux = arr_word;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q  <= '0;
      tog_q <= 1'b0;
    end else begin
      if (rd_en) rd_q <= rd_mux;
      if (op_start) tog_q <= 1'b0;
      else if (rd_en && busy_w) tog_q <= ~tog_q;
    end
  end

  assign rd_data = rd_q;
  assign busy    = busy_w;

  // R12
  busy_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_BUSY) == busy_w);

  // R12
  no_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> !op_start);

  // R6
  erase_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && busy_w && is_erase) |=> (rd_data[7] == 1'b0 && rd_data[15:8] == 8'h00));

endmodule

// File: tb/tb_nor_cmd_flash.sv
module tb_nor_cmd_flash;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic [15:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        busy;

  int checks = 0;
  int errors = 0;
  string phase = "R13";

  nor_cmd_flash dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata),
    .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data), .busy(busy)
  );

  always #10 clk = ~clk;

  // ---------------- behavioural reference model ----------------
  localparam int M_BUSY = 8;
  localparam int M_SECW = 256;
  logic [15:0] m_mem [int];
  string       m_mode = "array";
  int          m_left = 0;
  int          m_kind = 0;   // 0 program, 1 sector erase, 2 chip erase
  int          m_addr = 0;
  logic [15:0] m_data = '0;
  bit          m_back_byp = 0;
  bit          m_tog = 0;
  logic [15:0] exp_rd = '0;
  bit          exp_busy = 0;

  function automatic logic [15:0] m_word(int a);
    return m_mem.exists(a) ? m_mem[a] : 16'hFFFF;
  endfunction

  function automatic logic [15:0] m_read(int a);
    int off = a % 256;
    if (m_mode == "id") begin
      if (off == 0) return 16'h00BF;
      if (off == 1) return 16'h236D;
      return 16'h0000;
    end
    if (m_mode == "query") begin
      if (off == 'h10) return 16'h0051;
      if (off == 'h11) return 16'h0052;
      if (off == 'h12) return 16'h0059;
      if (off == 'h2C) return 16'h0001;
      if (off == 'h2D) return 16'h0003;
      if (off == 'h2F) return 16'h0002;
      return 16'h0000;
    end
    return m_word(a % 1024);
  endfunction

  task automatic m_begin(int kind, int a, logic [15:0] d);
    m_kind = kind; m_addr = a % 1024; m_data = d;
    m_back_byp = (m_mode == "bprog");
    m_left = M_BUSY; m_tog = 0; m_mode = "busy";
  endtask

  task automatic m_write(int a, logic [15:0] d);
    int lo = a % 2048;
    logic [7:0] c = d[7:0];
    if (m_mode == "prog" || m_mode == "bprog") m_begin(0, a, d);
    else if (c == 8'hF0) m_mode = "array";
    else if (m_mode == "array") begin
      if (c == 8'hAA && lo == 'h555) m_mode = "k1";
      else if (c == 8'h98 && lo == 'h55) m_mode = "query";
    end else if (m_mode == "k1") m_mode = (c == 8'h55 && lo == 'h2AA) ? "k2" : "array";
    else if (m_mode == "k2") begin
      m_mode = "array";
      if (lo == 'h555) begin
        if (c == 8'h90) m_mode = "id";
        else if (c == 8'hA0) m_mode = "prog";
        else if (c == 8'h80) m_mode = "e1";
        else if (c == 8'h20) m_mode = "bypass";
      end
    end else if (m_mode == "e1") m_mode = (c == 8'hAA && lo == 'h555) ? "e2" : "array";
    else if (m_mode == "e2") m_mode = (c == 8'h55 && lo == 'h2AA) ? "e3" : "array";
    else if (m_mode == "e3") begin
      if (c == 8'h30) m_begin(1, a, d);
      else if (c == 8'h10 && lo == 'h555) m_begin(2, a, d);
      else m_mode = "array";
    end else if (m_mode == "bypass") begin
      if (c == 8'h00) m_mode = "array";
      else if (c == 8'hA0) m_mode = "bprog";
    end
  endtask

  task automatic m_finish_op();
    if (m_kind == 0) m_mem[m_addr] = m_word(m_addr) & m_data;
    else if (m_kind == 2) m_mem.delete();
    else begin
      int base = (m_addr / M_SECW) * M_SECW;
      for (int i = base; i < base + M_SECW; i++)
        if (m_mem.exists(i)) m_mem.delete(i);
    end
    m_mode = m_back_byp ? "bypass" : "array";
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mem.delete(); m_mode = "array"; m_left = 0; m_tog = 0;
      exp_rd = '0; exp_busy = 0;
    end else begin
      if (m_left > 0) begin
        if (rd_en) begin
          exp_rd = {8'h00, (m_kind == 0) ? ~m_data[7] : 1'b0, m_tog, 6'b0};
          m_tog = !m_tog;
        end
        if (m_left == 1) m_finish_op();
        m_left--;
      end else begin
        if (rd_en) exp_rd = m_read(int'(addr));
        if (wr_en) m_write(int'(addr), wdata);
      end
      exp_busy = (m_left > 0);
    end
  end

  // Cycle-by-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (rd_data !== exp_rd || busy !== exp_busy) begin
        errors++;
        $display("FAIL %s model: rd_data %h busy %b expected %h %b",
                 phase, rd_data, busy, exp_rd, exp_busy);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic expect_eq(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [15:0] d);
    addr = 16'(a); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(int a, output logic [15:0] v);
    addr = 16'(a); rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic keys();
    wr('h555, 16'h00AA);
    wr('h2AA, 16'h0055);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired in %s", phase);
    summary();
  end

  initial begin
    logic [15:0] v;
    logic [15:0] v2;
    int n;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    phase = "R13";
    expect_eq("R13 busy after reset", 16'(busy), 16'h0);
    expect_eq("R13 rd_data after reset", rd_data, 16'h0000);
    rd('h3FF, v); expect_eq("R13 array erased", v, 16'hFFFF);

    phase = "R1";
    keys(); wr('h555, 16'h0090);
    rd(0, v); expect_eq("R1 maker code", v, 16'h00BF);
    rd(1, v); expect_eq("R1 device code", v, 16'h236D);
    rd(7, v); expect_eq("R1 other offset", v, 16'h0000);
    phase = "R2";
    wr('h1234, 16'h00F0);
    rd(0, v); expect_eq("R2 reset from identification", v, 16'hFFFF);

    phase = "R9";
    wr('h5555, 16'h00AA); wr('h2AAA, 16'h0055); wr('h5555, 16'h0090);
    rd(0, v); expect_eq("R9 high address bits ignored", v, 16'h00BF);
    wr(0, 16'h00F0);

    phase = "R10";
    wr('h55, 16'h0098);
    rd('h10, v); expect_eq("R10 Q", v, 16'h0051);
    rd('h11, v); expect_eq("R10 R", v, 16'h0052);
    rd('h12, v); expect_eq("R10 Y", v, 16'h0059);
    rd('h2C, v); expect_eq("R10 regions", v, 16'h0001);
    rd('h2D, v); expect_eq("R10 count low", v, 16'h0003);
    rd('h2E, v); expect_eq("R10 count high", v, 16'h0000);
    rd('h2F, v); expect_eq("R10 size low", v, 16'h0002);
    rd('h30, v); expect_eq("R10 size high", v, 16'h0000);
    phase = "R2";
    wr(0, 16'h00F0);
    rd('h10, v); expect_eq("R2 reset from query", v, 16'hFFFF);
    wr('h555, 16'h00AA); wr(5, 16'h00F0);
    wr('h2AA, 16'h0055); wr('h555, 16'h0090);
    rd(0, v); expect_eq("R2 reset from partial sequence", v, 16'hFFFF);

    phase = "R6";
    keys(); wr('h555, 16'h00A0); wr('h100, 16'h0055);
    rd('h100, v); expect_eq("R6 program status first", v, 16'h0080);
    rd('h100, v); expect_eq("R6 program status toggles", v, 16'h00C0);
    wait_idle();
    phase = "R7";
    rd('h100, v); rd('h100, v2);
    expect_eq("R3 first program", v, 16'h0055);
    expect_eq("R7 stable after completion", v2, v);
    phase = "R3";
    keys(); wr('h555, 16'h00A0); wr('h100, 16'h00A5);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    expect_eq("R6 busy length", 16'(n), 16'(M_BUSY));
    rd('h100, v); expect_eq("R3 AND-only program", v, 16'h0005);

    phase = "R4";
    keys(); wr('h555, 16'h00A0); wr('h000, 16'h1234); wait_idle();
    keys(); wr('h555, 16'h00A0); wr('h2FF, 16'hABCD); wait_idle();
    keys(); wr('h555, 16'h0080); keys(); wr('h1FF, 16'h0030);
    rd('h100, v); expect_eq("R6 erase status first", v, 16'h0000);
    rd('h100, v); expect_eq("R6 erase status toggles", v, 16'h0040);
    wait_idle();
    rd('h100, v); expect_eq("R4 target sector erased", v, 16'hFFFF);
    rd('h000, v); expect_eq("R4 sector 0 kept", v, 16'h1234);
    rd('h2FF, v); expect_eq("R4 sector 2 kept", v, 16'hABCD);

    phase = "R12";
    keys(); wr('h555, 16'h00A0); wr('h010, 16'h0F0F);
    wr(0, 16'h00F0); wr('h555, 16'h00AA);
    wait_idle();
    wr('h2AA, 16'h0055); wr('h555, 16'h0090);
    rd(0, v); expect_eq("R12 writes during busy ignored", v, 16'h1234);
    rd('h10, v); expect_eq("R12 program still completed", v, 16'h0F0F);

    phase = "R11";
    wr('h555, 16'h00AA); wr('h123, 16'h0055);
    wr('h555, 16'h00A0); wr('h020, 16'h0000);
    expect_eq("R11 no operation after abort", 16'(busy), 16'h0);
    rd('h20, v); expect_eq("R11 aborted program", v, 16'hFFFF);
    keys(); wr('h555, 16'h0080); wr(0, 16'h0030);
    expect_eq("R11 no erase after abort", 16'(busy), 16'h0);
    rd(0, v); expect_eq("R11 aborted erase", v, 16'h1234);

    phase = "R5";
    keys(); wr('h555, 16'h0080); keys(); wr('h555, 16'h0010);
    rd(0, v); expect_eq("R6 chip erase status", v, 16'h0000);
    rd(0, v); expect_eq("R6 chip erase toggle", v, 16'h0040);
    wait_idle();
    rd('h000, v); expect_eq("R5 word 0 erased", v, 16'hFFFF);
    rd('h2FF, v); expect_eq("R5 sector 2 erased", v, 16'hFFFF);
    rd('h010, v); expect_eq("R5 word 0x10 erased", v, 16'hFFFF);

    phase = "R8";
    keys(); wr('h555, 16'h0020);
    wr('h555, 16'h00A0); wr(0, 16'h0001); wait_idle();
    wr('h555, 16'h00A0); wr(1, 16'h0023); wait_idle();
    wr('h555, 16'h00A0); wr(2, 16'h0045); wait_idle();
    wr(3, 16'h00A0); wr(3, 16'h0067); wait_idle();
    wr(0, 16'h0000);
    wr(4, 16'h00A0); wr(4, 16'h0089);
    expect_eq("R8 no operation after exit", 16'(busy), 16'h0);
    rd(0, v); expect_eq("R8 bypass word 0", v, 16'h0001);
    rd(1, v); expect_eq("R8 bypass word 1", v, 16'h0023);
    rd(2, v); expect_eq("R8 bypass word 2", v, 16'h0045);
    rd(3, v); expect_eq("R8 program at any address", v, 16'h0067);
    rd(4, v); expect_eq("R8 bare program ignored after exit", v, 16'hFFFF);

    repeat (2) @(negedge clk);
    summary();
  end

endmodule